// File: doc/BRIEF.md
# Error-Record Count Register Access Resolver

This block sits beside the system-register read path of a processor core and settles what a coprocessor-style read of the error-record identification register does. Each request carries the instruction's encoding fields. It also carries the requesting exception level, the execution width (32-bit or 64-bit) of levels 2 and 3, whether the core is in monitor mode, and the trap-control bits in both their 64-bit and 32-bit register forms. The block resolves these into exactly one outcome: the read completes, the instruction is undefined, the access traps to the hypervisor level, or the access traps to the secure-monitor level.

Conditions are tested in a fixed priority that depends on the requesting level. Traps also carry a trap kind and a syndrome code. A completed read returns a word whose low half is a configured count of accessible error records. The verdict is registered and presented one cycle after the request pulse, together with a response strobe. Taking the exception, writing syndrome registers and the records themselves belong to other blocks.

Top module: `errid_access_resolver`

## Requirements
- R1: A request decodes only when coprocessor = 15, opc1 = 0, CRn = 5, CRm = 3 and opc2 = 0. Any other encoding raises `rsp_not_decoded`, keeps all four outcome outputs low and gives zero read data.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. Outside such cycles every response output is zero, including after reset.
- R3: For every decoded request, exactly one of `rsp_read_ok`, `rsp_undef`, `rsp_trap_hyp`, `rsp_trap_mon` is high.
- R4: A request from level 0 (`cur_level` = 0) is undefined, whatever the control bits are.
- R5: From level 1 or 2, if level 3 exists, `early_undef_prio` is high and the selected level-3 error-trap bit is set, the result is undefined. This check takes priority over every trap.
- R6: From level 1, when level 2 is enabled and either selected level-2 trap bit (register-group trap or error trap) is set, the access traps to the hypervisor with syndrome 0x03. The trap kind is 1 (64-bit system access) when level 2 is 64-bit and 2 (32-bit hypervisor trap) when level 2 is 32-bit. These bits have no effect when level 2 is disabled.
- R7: From level 1 or 2, when level 3 exists and its selected error-trap bit is set (R5 and R6 not applying), the result is undefined if `sdd_undef` is high. Otherwise the access traps to the monitor: kind 1 with syndrome 0x03 when level 3 is 64-bit, or kind 3 (32-bit monitor trap) with syndrome 0 when level 3 is 32-bit.
- R8: From level 1, when level 3 is 32-bit and the core is in monitor mode, the level-3 error trap of R7 does not apply and the read completes.
- R9: From level 2, the level-2 trap bits have no effect.
- R10: From level 3, the access traps to the monitor (kind 3, syndrome 0) when not in monitor mode and the selected level-3 error-trap bit is set. Otherwise the read completes.
- R11: A completed read returns bits 31:16 = 0 and bits 15:0 = `RECORD_COUNT` (default 5). Read data is zero for every other outcome. Trap kind 0 and syndrome 0 accompany reads and undefined results.
- R12: Each trap bit is taken from its 64-bit form when its owning level (2 or 3) is 64-bit and from its 32-bit form when that level is 32-bit. The other form is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle request pulse |
| req_coproc | input | 4 | Coprocessor number field |
| req_opc1 | input | 3 | First opcode field |
| req_crn | input | 4 | Primary register field |
| req_crm | input | 4 | Secondary register field |
| req_opc2 | input | 3 | Second opcode field |
| cur_level | input | 2 | Requesting exception level, 0 to 3 |
| in_monitor_mode | input | 1 | Core currently in monitor mode |
| has_level3 | input | 1 | Level 3 implemented |
| level3_is32 | input | 1 | Level 3 runs in 32-bit state |
| level2_enabled | input | 1 | Level 2 enabled for the current state |
| level2_is32 | input | 1 | Level 2 runs in 32-bit state |
| early_undef_prio | input | 1 | Level-3 early-undefined priority condition |
| sdd_undef | input | 1 | Secure-debug-disable undefined condition |
| l3_err_trap_w64 | input | 1 | Level-3 error-trap bit, 64-bit register form |
| l3_err_trap_w32 | input | 1 | Level-3 error-trap bit, 32-bit register form |
| l2_grp_trap_w64 | input | 1 | Level-2 register-group trap bit, 64-bit form |
| l2_grp_trap_w32 | input | 1 | Level-2 register-group trap bit, 32-bit form |
| l2_err_trap_w64 | input | 1 | Level-2 error-trap bit, 64-bit form |
| l2_err_trap_w32 | input | 1 | Level-2 error-trap bit, 32-bit form |
| rsp_valid | output | 1 | Response strobe |
| rsp_not_decoded | output | 1 | Encoding did not match |
| rsp_read_ok | output | 1 | Read completed |
| rsp_undef | output | 1 | Undefined instruction |
| rsp_trap_hyp | output | 1 | Trap to hypervisor level |
| rsp_trap_mon | output | 1 | Trap to monitor level |
| rsp_trap_kind | output | 2 | 0 none, 1 64-bit system access, 2 32-bit hypervisor, 3 32-bit monitor |
| rsp_syndrome | output | 6 | Syndrome code |
| rsp_rdata | output | 32 | Read data |

## Verification
The assertions assume that the context inputs are stable throughout the cycle that carries `req_valid`, and that `cur_level` is one of the four levels with a consistent context. For example, level 3 is present whenever a request comes from level 3, and the monitor-mode flag is set only where level 3 is 32-bit. The bench changes context and encoding fields only on the falling edge, together with the request pulse. It also keeps every scenario inside such consistent configurations, so the assertions judge only combinations the core can produce.

// File: rtl/errid_access_pkg.sv
// Package: shared types for the error-record count register access resolver.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package errid_access_pkg;

    localparam int SYN_W        = 6;
    localparam logic [SYN_W-1:0] SYN_SYSREG = 6'h03;

    // Trap kind as seen on rsp_trap_kind.
    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_SYS64 = 2'd1,
        KIND_HYP32 = 2'd2,
        KIND_MON32 = 2'd3
    } trap_kind_e;

    // The single outcome of a decoded request.
    typedef enum logic [1:0] {
        OUT_READ  = 2'd0,
        OUT_UNDEF = 2'd1,
        OUT_HYP   = 2'd2,
        OUT_MON   = 2'd3
    } outcome_e;

    typedef struct packed {
        outcome_e             outcome;
        trap_kind_e           kind;
        logic [SYN_W-1:0]     syndrome;
    } verdict_t;

endpackage

// File: rtl/errid_enc_match.sv
// Module: errid_enc_match
// Compares the five instruction encoding fields with the target register's
// encoding. The target encoding is supplied by parameters.
// Assumes: fields are stable while req_valid is high.
module errid_enc_match #(
    parameter logic [3:0] COPROC = 4'd15,
    parameter logic [2:0] OPC1   = 3'd0,
    parameter logic [3:0] CRN    = 4'd5,
    parameter logic [3:0] CRM    = 4'd3,
    parameter logic [2:0] OPC2   = 3'd0
) (
    input  logic [3:0] coproc,
    input  logic [2:0] opc1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] opc2,
    output logic       hit
);

    logic [4:0] field_eq;

    // Purpose: per-field equality, all must agree for a hit.
    always_comb begin
        field_eq[0] = (coproc == COPROC);
        field_eq[1] = (opc1   == OPC1);
        field_eq[2] = (crn    == CRN);
        field_eq[3] = (crm    == CRM);
        field_eq[4] = (opc2   == OPC2);
        hit         = &field_eq;
    end

endmodule

// File: rtl/errid_form_select.sv
// Module: errid_form_select
// Picks the 64-bit or the 32-bit register form of one trap-control bit,
// according to the execution width of the level that owns the bit.
// Assumes: the owning level's width flag is stable during a request.
module errid_form_select (
    input  logic owner_is32,
    input  logic bit_w64,
    input  logic bit_w32,
    output logic bit_sel
);

    // Purpose: width-driven mux; the unused form has no influence.
    always_comb begin
        bit_sel = owner_is32 ? bit_w32 : bit_w64;
    end

endmodule

// File: rtl/errid_priority.sv
// Module: errid_priority
// Resolves the fixed-priority chain of undefined and trap conditions for one
// request into a single verdict. The chain depends on the requesting level.
// Assumes: trap bits have already been reduced to their selected form.
module errid_priority
    import errid_access_pkg::*;
(
    input  logic [1:0] cur_level,
    input  logic       in_monitor_mode,
    input  logic       has_level3,
    input  logic       level3_is32,
    input  logic       level2_enabled,
    input  logic       level2_is32,
    input  logic       early_undef_prio,
    input  logic       sdd_undef,
    input  logic       l3_err_sel,
    input  logic       l2_grp_sel,
    input  logic       l2_err_sel,
    output verdict_t   verdict
);

    localparam verdict_t V_READ  = '{OUT_READ,  KIND_NONE,  '0};
    localparam verdict_t V_UNDEF = '{OUT_UNDEF, KIND_NONE,  '0};
    localparam verdict_t V_MON32 = '{OUT_MON,   KIND_MON32, '0};

    logic     l3_gate;
    logic     early_hit;
    logic     hyp_hit;
    logic     l3_masked_l1;
    verdict_t hyp_v;
    verdict_t l3_v;

    // Purpose: shared terms used by the level 1 and level 2 chains.
    always_comb begin
        l3_gate      = has_level3 && l3_err_sel;
        early_hit    = l3_gate && early_undef_prio;
        hyp_hit      = level2_enabled && (l2_grp_sel || l2_err_sel);
        l3_masked_l1 = level3_is32 && in_monitor_mode;
    end

    // Purpose: verdict of a hypervisor trap, shaped by level-2 width.
    always_comb begin
        hyp_v.outcome  = OUT_HYP;
        hyp_v.kind     = level2_is32 ? KIND_HYP32 : KIND_SYS64;
        hyp_v.syndrome = SYN_SYSREG;
    end

    // Purpose: verdict of a level-3 error trap from level 1 or 2.
    always_comb begin
        if (sdd_undef) begin
            l3_v = V_UNDEF;
        end else if (level3_is32) begin
            l3_v = V_MON32;
        end else begin
            l3_v.outcome  = OUT_MON;
            l3_v.kind     = KIND_SYS64;
            l3_v.syndrome = SYN_SYSREG;
        end
    end

    // Purpose: walk the priority chain for the requesting level.
    always_comb begin
        unique case (cur_level)
            2'd0: verdict = V_UNDEF;
            2'd1: begin
                if (early_hit)                        verdict = V_UNDEF;
                else if (hyp_hit)                     verdict = hyp_v;
                else if (l3_gate && !l3_masked_l1)    verdict = l3_v;
                else                                  verdict = V_READ;
            end
            2'd2: begin
                if (early_hit)                        verdict = V_UNDEF;
                else if (l3_gate)                     verdict = l3_v;
                else                                  verdict = V_READ;
            end
            default: begin
                if (!in_monitor_mode && l3_err_sel)   verdict = V_MON32;
                else                                  verdict = V_READ;
            end
        endcase
    end

    // A 32-bit monitor trap never carries a syndrome code.
    always_comb begin
        if (verdict.kind == KIND_MON32) begin
            AST_MON32_NO_SYNDROME: assert (verdict.syndrome == '0); // R7
        end
    end

endmodule

// File: rtl/errid_rsp_reg.sv
// Module: errid_rsp_reg
// Registers the verdict into one-hot outcome outputs, trap kind, syndrome and
// read data, one cycle after the request pulse.
// Assumes: verdict and hit are valid in the cycle req_valid is high.
module errid_rsp_reg
    import errid_access_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int COUNT_W      = 16,
    parameter int RECORD_COUNT = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               hit,
    input  verdict_t           verdict,
    output logic               rsp_valid,
    output logic               rsp_not_decoded,
    output logic               rsp_read_ok,
    output logic               rsp_undef,
    output logic               rsp_trap_hyp,
    output logic               rsp_trap_mon,
    output logic [1:0]         rsp_trap_kind,
    output logic [SYN_W-1:0]   rsp_syndrome,
    output logic [DATA_W-1:0]  rsp_rdata
);

    localparam int PAD_W = DATA_W - COUNT_W;
    localparam logic [COUNT_W-1:0] COUNT_VAL = COUNT_W'(RECORD_COUNT);
    localparam logic [DATA_W-1:0]  READ_WORD = {{PAD_W{1'b0}}, COUNT_VAL};

    logic accept;

    // Purpose: a decoded request is the only one that yields an outcome.
    always_comb begin
        accept = req_valid && hit;
    end

    // Purpose: capture the response; clear everything when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid       <= 1'b0;
            rsp_not_decoded <= 1'b0;
            rsp_read_ok     <= 1'b0;
            rsp_undef       <= 1'b0;
            rsp_trap_hyp    <= 1'b0;
            rsp_trap_mon    <= 1'b0;
            rsp_trap_kind   <= 2'd0;
            rsp_syndrome    <= '0;
            rsp_rdata       <= '0;
        end else begin
            rsp_valid       <= req_valid;
            rsp_not_decoded <= req_valid && !hit;
            rsp_read_ok     <= accept && (verdict.outcome == OUT_READ);
            rsp_undef       <= accept && (verdict.outcome == OUT_UNDEF);
            rsp_trap_hyp    <= accept && (verdict.outcome == OUT_HYP);
            rsp_trap_mon    <= accept && (verdict.outcome == OUT_MON);
            rsp_trap_kind   <= accept ? verdict.kind : 2'd0;
            rsp_syndrome    <= accept ? verdict.syndrome : '0;
            rsp_rdata       <= (accept && verdict.outcome == OUT_READ) ? READ_WORD : '0;
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_not_decoded) |->
        $countones({rsp_read_ok, rsp_undef, rsp_trap_hyp, rsp_trap_mon}) == 1); // R3

    AST_UNDECODED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_not_decoded |->
        !(rsp_read_ok || rsp_undef || rsp_trap_hyp || rsp_trap_mon) && rsp_rdata == '0); // R1

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_not_decoded || rsp_read_ok || rsp_undef ||
                         rsp_trap_hyp || rsp_trap_mon) && rsp_rdata == '0); // R2

    AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_read_ok |-> rsp_rdata[DATA_W-1:COUNT_W] == '0); // R11

endmodule

// File: rtl/errid_access_resolver.sv
// Module: errid_access_resolver (top)
// Decodes a coprocessor-style read request for the error-record count
// register, resolves its undefined/trap/read outcome and registers the
// response one cycle later.
// Assumes: context inputs are stable in the cycle req_valid is high.
module errid_access_resolver
    import errid_access_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int COUNT_W      = 16,
    parameter int RECORD_COUNT = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  logic [3:0]   req_coproc,
    input  logic [2:0]   req_opc1,
    input  logic [3:0]   req_crn,
    input  logic [3:0]   req_crm,
    input  logic [2:0]   req_opc2,
    input  logic [1:0]   cur_level,
    input  logic         in_monitor_mode,
    input  logic         has_level3,
    input  logic         level3_is32,
    input  logic         level2_enabled,
    input  logic         level2_is32,
    input  logic         early_undef_prio,
    input  logic         sdd_undef,
    input  logic         l3_err_trap_w64,
    input  logic         l3_err_trap_w32,
    input  logic         l2_grp_trap_w64,
    input  logic         l2_grp_trap_w32,
    input  logic         l2_err_trap_w64,
    input  logic         l2_err_trap_w32,
    output logic         rsp_valid,
    output logic         rsp_not_decoded,
    output logic         rsp_read_ok,
    output logic         rsp_undef,
    output logic         rsp_trap_hyp,
    output logic         rsp_trap_mon,
    output logic [1:0]   rsp_trap_kind,
    output logic [5:0]   rsp_syndrome,
    output logic [31:0]  rsp_rdata
);

    localparam int N_BITS = 3;  // level-3 error, level-2 group, level-2 error

    logic              hit;
    logic [N_BITS-1:0] owner_is32;
    logic [N_BITS-1:0] form_w64;
    logic [N_BITS-1:0] form_w32;
    logic [N_BITS-1:0] form_sel;
    verdict_t          verdict;
    logic [DATA_W-1:0] rdata_int;

    errid_enc_match u_match (
        .coproc (req_coproc),
        .opc1   (req_opc1),
        .crn    (req_crn),
        .crm    (req_crm),
        .opc2   (req_opc2),
        .hit    (hit)
    );

    // Purpose: gather trap bits with the level that owns each.
    always_comb begin
        owner_is32 = {level2_is32, level2_is32, level3_is32};
        form_w64   = {l2_err_trap_w64, l2_grp_trap_w64, l3_err_trap_w64};
        form_w32   = {l2_err_trap_w32, l2_grp_trap_w32, l3_err_trap_w32};
    end

    for (genvar i = 0; i < N_BITS; i++) begin : g_form
        errid_form_select u_sel (
            .owner_is32 (owner_is32[i]),
            .bit_w64    (form_w64[i]),
            .bit_w32    (form_w32[i]),
            .bit_sel    (form_sel[i])
        );
    end

    errid_priority u_prio (
        .cur_level        (cur_level),
        .in_monitor_mode  (in_monitor_mode),
        .has_level3       (has_level3),
        .level3_is32      (level3_is32),
        .level2_enabled   (level2_enabled),
        .level2_is32      (level2_is32),
        .early_undef_prio (early_undef_prio),
        .sdd_undef        (sdd_undef),
        .l3_err_sel       (form_sel[0]),
        .l2_grp_sel       (form_sel[1]),
        .l2_err_sel       (form_sel[2]),
        .verdict          (verdict)
    );

    errid_rsp_reg #(
        .DATA_W       (DATA_W),
        .COUNT_W      (COUNT_W),
        .RECORD_COUNT (RECORD_COUNT)
    ) u_rsp (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .hit             (hit),
        .verdict         (verdict),
        .rsp_valid       (rsp_valid),
        .rsp_not_decoded (rsp_not_decoded),
        .rsp_read_ok     (rsp_read_ok),
        .rsp_undef       (rsp_undef),
        .rsp_trap_hyp    (rsp_trap_hyp),
        .rsp_trap_mon    (rsp_trap_mon),
        .rsp_trap_kind   (rsp_trap_kind),
        .rsp_syndrome    (rsp_syndrome),
        .rsp_rdata       (rdata_int)
    );

    // Purpose: present the data word on the fixed-width port.
    always_comb begin
        rsp_rdata = 32'(rdata_int);
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2

    AST_LEVEL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit && cur_level == 2'd0) |=> rsp_undef); // R4

    AST_LEVEL3_MONMODE_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit && cur_level == 2'd3 && in_monitor_mode) |=> rsp_read_ok); // R10

    AST_HYP_TRAP_SYNDROME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap_hyp |-> rsp_syndrome == 6'h03 && rsp_trap_kind != 2'd0); // R6

endmodule

// File: tb/sim_errid_access_resolver.sv
// Directed bench: one task per scenario, each checks its own responses.
module sim_errid_access_resolver;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [3:0] req_coproc = 4'd0;
    logic [2:0] req_opc1 = 3'd0;
    logic [3:0] req_crn = 4'd0;
    logic [3:0] req_crm = 4'd0;
    logic [2:0] req_opc2 = 3'd0;
    logic [1:0] cur_level = 2'd0;
    logic in_mon = 1'b0, has3 = 1'b0, l3_32 = 1'b0, l2_en = 1'b0, l2_32 = 1'b0;
    logic early = 1'b0, sdd = 1'b0;
    logic l3e64 = 1'b0, l3e32 = 1'b0, g64 = 1'b0, g32 = 1'b0, e64 = 1'b0, e32 = 1'b0;

    logic rsp_valid, rsp_nd, rsp_ok, rsp_ud, rsp_hyp, rsp_mon;
    logic [1:0]  rsp_kind;
    logic [5:0]  rsp_syn;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [31:0] READ_WORD = 32'h0000_0005;

    always #4 clk = ~clk;  // 125 MHz

    errid_access_resolver u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_coproc(req_coproc), .req_opc1(req_opc1), .req_crn(req_crn),
        .req_crm(req_crm), .req_opc2(req_opc2), .cur_level(cur_level),
        .in_monitor_mode(in_mon), .has_level3(has3), .level3_is32(l3_32),
        .level2_enabled(l2_en), .level2_is32(l2_32), .early_undef_prio(early),
        .sdd_undef(sdd), .l3_err_trap_w64(l3e64), .l3_err_trap_w32(l3e32),
        .l2_grp_trap_w64(g64), .l2_grp_trap_w32(g32),
        .l2_err_trap_w64(e64), .l2_err_trap_w32(e32),
        .rsp_valid(rsp_valid), .rsp_not_decoded(rsp_nd), .rsp_read_ok(rsp_ok),
        .rsp_undef(rsp_ud), .rsp_trap_hyp(rsp_hyp), .rsp_trap_mon(rsp_mon),
        .rsp_trap_kind(rsp_kind), .rsp_syndrome(rsp_syn), .rsp_rdata(rsp_rdata)
    );

    task automatic clear_ctx();
        in_mon = 0; has3 = 0; l3_32 = 0; l2_en = 0; l2_32 = 0; early = 0; sdd = 0;
        l3e64 = 0; l3e32 = 0; g64 = 0; g32 = 0; e64 = 0; e32 = 0;
    endtask

    // Issue one request at a falling edge; response is sampled one falling edge later.
    task automatic issue(input logic [1:0] lvl, input logic [3:0] cp, input logic [2:0] o1,
                         input logic [3:0] rn, input logic [3:0] rm, input logic [2:0] o2);
        @(negedge clk);
        cur_level = lvl; req_coproc = cp; req_opc1 = o1; req_crn = rn; req_crm = rm;
        req_opc2 = o2; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic issue_match(input logic [1:0] lvl);
        issue(lvl, 4'd15, 3'd0, 4'd5, 4'd3, 3'd0);
    endtask

    // Compare the full response word against expectations.
    task automatic expect_rsp(input string tag, input logic v, input logic nd, input logic ok,
                              input logic ud, input logic hy, input logic mo,
                              input logic [1:0] kind, input logic [5:0] syn, input logic [31:0] data);
        logic [45:0] act, exp;
        act = {rsp_valid, rsp_nd, rsp_ok, rsp_ud, rsp_hyp, rsp_mon, rsp_kind, rsp_syn, rsp_rdata};
        exp = {v, nd, ok, ud, hy, mo, kind, syn, data};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual v=%b nd=%b ok=%b ud=%b hyp=%b mon=%b kind=%0d syn=%h data=%h expected v=%b nd=%b ok=%b ud=%b hyp=%b mon=%b kind=%0d syn=%h data=%h",
                     tag, act[45], act[44], act[43], act[42], act[41], act[40], act[39:38], act[37:32], act[31:0],
                     exp[45], exp[44], exp[43], exp[42], exp[41], exp[40], exp[39:38], exp[37:32], exp[31:0]);
        end
    endtask

    task automatic exp_read(input string tag);
        expect_rsp(tag, 1, 0, 1, 0, 0, 0, 2'd0, 6'h00, READ_WORD);
    endtask
    task automatic exp_undef(input string tag);
        expect_rsp(tag, 1, 0, 0, 1, 0, 0, 2'd0, 6'h00, 32'h0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        expect_rsp("R2 reset state", 0, 0, 0, 0, 0, 0, 2'd0, 6'h00, 32'h0);
    endtask

    task automatic t_decode();
        clear_ctx();
        issue(2'd1, 4'd14, 3'd0, 4'd5, 4'd3, 3'd0);
        expect_rsp("R1 coproc mismatch", 1, 1, 0, 0, 0, 0, 2'd0, 6'h00, 32'h0);
        issue(2'd1, 4'd15, 3'd1, 4'd5, 4'd3, 3'd0);
        expect_rsp("R1 opc1 mismatch", 1, 1, 0, 0, 0, 0, 2'd0, 6'h00, 32'h0);
        issue(2'd1, 4'd15, 3'd0, 4'd4, 4'd3, 3'd0);
        expect_rsp("R1 crn mismatch", 1, 1, 0, 0, 0, 0, 2'd0, 6'h00, 32'h0);
        issue(2'd1, 4'd15, 3'd0, 4'd5, 4'd2, 3'd0);
        expect_rsp("R1 crm mismatch", 1, 1, 0, 0, 0, 0, 2'd0, 6'h00, 32'h0);
        issue(2'd0, 4'd15, 3'd0, 4'd5, 4'd3, 3'd1);
        expect_rsp("R1 opc2 mismatch at level0", 1, 1, 0, 0, 0, 0, 2'd0, 6'h00, 32'h0);
        issue_match(2'd1);
        exp_read("R11 R3 plain read level1");
        @(negedge clk);
        expect_rsp("R2 idle after response", 0, 0, 0, 0, 0, 0, 2'd0, 6'h00, 32'h0);
    endtask

    task automatic t_level0();
        clear_ctx();
        issue_match(2'd0);
        exp_undef("R4 level0 clear context");
        l2_en = 1; g64 = 1; has3 = 1; l3e64 = 1;
        issue_match(2'd0);
        exp_undef("R4 level0 with traps set");
    endtask

    task automatic t_level1_early();
        clear_ctx();
        has3 = 1; l3e64 = 1; early = 1; l2_en = 1; g64 = 1; e64 = 1;
        issue_match(2'd1);
        exp_undef("R5 early undef beats hyp trap");
        clear_ctx();
        has3 = 1; l3_32 = 1; l3e64 = 1; early = 1;
        issue_match(2'd1);
        exp_read("R12 R5 unselected wide form ignored");
    endtask

    task automatic t_level1_hyp();
        clear_ctx();
        l2_en = 1; g64 = 1;
        issue_match(2'd1);
        expect_rsp("R6 group trap l2 64-bit", 1, 0, 0, 0, 1, 0, 2'd1, 6'h03, 32'h0);
        clear_ctx();
        l2_en = 1; l2_32 = 1; e32 = 1;
        issue_match(2'd1);
        expect_rsp("R6 error trap l2 32-bit", 1, 0, 0, 0, 1, 0, 2'd2, 6'h03, 32'h0);
        clear_ctx();
        l2_en = 1; l2_32 = 1; g64 = 1; e64 = 1;
        issue_match(2'd1);
        exp_read("R12 l2 32-bit ignores wide forms");
        clear_ctx();
        g64 = 1; e64 = 1;
        issue_match(2'd1);
        exp_read("R6 level2 disabled no trap");
        clear_ctx();
        l2_en = 1; e64 = 1; has3 = 1; l3e64 = 1;
        issue_match(2'd1);
        expect_rsp("R6 hyp trap beats level3 trap", 1, 0, 0, 0, 1, 0, 2'd1, 6'h03, 32'h0);
    endtask

    task automatic t_level1_l3();
        clear_ctx();
        has3 = 1; l3e64 = 1;
        issue_match(2'd1);
        expect_rsp("R7 l3 64-bit trap", 1, 0, 0, 0, 0, 1, 2'd1, 6'h03, 32'h0);
        sdd = 1;
        issue_match(2'd1);
        exp_undef("R7 sdd gives undef");
        clear_ctx();
        has3 = 1; l3_32 = 1; l3e32 = 1;
        issue_match(2'd1);
        expect_rsp("R7 l3 32-bit monitor trap", 1, 0, 0, 0, 0, 1, 2'd3, 6'h00, 32'h0);
        in_mon = 1;
        issue_match(2'd1);
        exp_read("R8 monitor mode masks l3 trap");
        clear_ctx();
        l3e64 = 1;
        issue_match(2'd1);
        exp_read("R7 no level3 present");
    endtask

    task automatic t_level2();
        clear_ctx();
        l2_en = 1; g64 = 1; e64 = 1;
        issue_match(2'd2);
        exp_read("R9 level2 ignores hyp bits");
        has3 = 1; l3e64 = 1;
        issue_match(2'd2);
        expect_rsp("R7 level2 l3 trap", 1, 0, 0, 0, 0, 1, 2'd1, 6'h03, 32'h0);
        early = 1;
        issue_match(2'd2);
        exp_undef("R5 level2 early undef");
    endtask

    task automatic t_level3();
        clear_ctx();
        has3 = 1; l3_32 = 1; l3e32 = 1;
        issue_match(2'd3);
        expect_rsp("R10 level3 not monitor traps", 1, 0, 0, 0, 0, 1, 2'd3, 6'h00, 32'h0);
        in_mon = 1;
        issue_match(2'd3);
        exp_read("R10 level3 monitor reads");
        in_mon = 0; l3e32 = 0; l3e64 = 1;
        issue_match(2'd3);
        exp_read("R12 R10 level3 ignores wide form");
    endtask

    initial begin
        clear_ctx();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_decode();
        t_level0();
        t_level1_early();
        t_level1_hyp();
        t_level1_l3();
        t_level2();
        t_level3();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule